// File: doc/BRIEF.md
# Hamming SEC-DED Codec for 8-bit Words

This block protects an 8-bit data word with a single-error-correcting, double-error-detecting Hamming code. The encoder side turns a data byte into a 13-bit codeword. The decoder side takes a 13-bit codeword, possibly corrupted in storage or transit, and returns the repaired data byte. It also raises a flag that tells the user whether a single error was repaired or an uncorrectable error was found. The two sides are independent: a memory wrapper writes `enc_code_o` into storage and feeds the stored word back on `dec_code_i`.

Within the codeword, vector bit `p-1` carries code position `p`, for p from 1 to 13. Check bits occupy the power-of-two positions 1, 2, 4 and 8. The eight data bits fill the remaining positions up to 12, and position 13 carries an overall parity bit. The decoder recomputes four check bits. It reads them as a binary position number (the syndrome) and weighs that number against the overall parity of all 13 bits. A parameter selects whether the results pass through one register stage or leave the block combinationally.

Top module: `hamming_secded_codec`

## Requirements
- R1: Data bits are placed MSB first. Data bit 7 goes to position 3, then bit 6 to 5, bit 5 to 6, bit 4 to 7, bit 3 to 9, bit 2 to 10, bit 1 to 11 and bit 0 to 12. Position p is codeword bit p-1.
- R2: The check bit at position 2^k (k = 0..3) is the XOR of every data position in 1..12 whose binary index has bit k set.
- R3: Position 13 is the even parity of positions 1..12, so every encoded word has even weight. Data 0x5B encodes to 13'h1DD8.
- R4: A word with exactly one flipped bit in positions 1..12 decodes to the original data with `dec_sec_o`=1 and `dec_ded_o`=0.
- R5: A word whose only flipped bit is position 13 decodes to the original data with `dec_sec_o`=1 and `dec_ded_o`=0.
- R6: A word with any two flipped bits gives `dec_ded_o`=1 and `dec_sec_o`=0. In that case `dec_data_o` carries the data positions of the received word unchanged.
- R7: When the overall parity is odd and the syndrome is 13, 14 or 15 (for example, positions 1, 4 and 8 all flipped), the word is reported as uncorrectable: `dec_ded_o`=1 and `dec_sec_o`=0, with the data positions passed through uncorrected.
- R8: An error-free codeword decodes to its data with both flags at 0.
- R9: With `OUT_REG`=1 (the default), all outputs change one clock after their inputs. While `rst_n` is low at a rising edge, all outputs become zero. With `OUT_REG`=0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| enc_data_i | input | 8 | Data byte to encode |
| enc_code_o | output | 13 | Codeword; bit p-1 is position p |
| dec_code_i | input | 13 | Received codeword to check and repair |
| dec_data_o | output | 8 | Repaired (or passed-through) data byte |
| dec_sec_o | output | 1 | A single error was found and repaired |
| dec_ded_o | output | 1 | An uncorrectable error was found |

## Verification
The assertions assume that `dec_code_i` and `enc_data_i` are driven to known values in every cycle, including the reset cycles. The clean-loopback property assumes that a received word equal to the encoder's output is error-free. The stimulus keeps to this by changing inputs only at falling edges and by driving zeros or valid codewords throughout. Corrupted words are built only by flipping chosen bits of a reference encoding, so the expected flags follow directly from the number and placement of the flips. Every single and double flip of all 256 data values is covered. This is combined with seeded random single flips and with triple flips chosen to land the syndrome above 12.

// File: rtl/hsd_pkg.sv
// Package: shared widths and position helpers for the SEC-DED codec.
// Assumes one fixed layout: check bits at power-of-two positions,
// data MSB-first in the remaining positions, overall parity last.
package hsd_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int HAM_W  = DATA_W + PAR_W;
    localparam int CODE_W = HAM_W + 1;

    // Returns the 1-based code position that holds data index idx (0 = MSB).
    function automatic int data_pos(input int idx);
        int n;
        int r;
        n = 0;
        r = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) r = p;
                n++;
            end
        end
        return r;
    endfunction

    // Extracts the data positions of a codeword without any correction.
    function automatic logic [DATA_W-1:0] raw_data(input logic [CODE_W-1:0] code);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < DATA_W; i++) d[DATA_W-1-i] = code[data_pos(i)-1];
        return d;
    endfunction
endpackage

// File: rtl/hsd_encoder.sv
// Module: combinational SEC-DED encoder.
// Places data bits, derives the four position check bits, then the
// overall even parity bit. Assumes the layout fixed in hsd_pkg.
module hsd_encoder
    import hsd_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HAM_W:1] pos;
    logic           par;

    // Fill data positions, then compute each check bit over its group.
    always_comb begin
        pos = '0;
        par = 1'b0;
        for (int i = 0; i < DATA_W; i++) pos[data_pos(i)] = data_i[DATA_W-1-i];
        for (int k = 0; k < PAR_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= HAM_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) par = par ^ pos[p];
            end
            pos[1 << k] = par;
        end
    end

    // Overall parity on top makes the full word even weight.
    assign code_o = {^pos, pos};
endmodule

// File: rtl/hsd_decoder.sv
// Module: combinational SEC-DED decoder.
// Computes the syndrome and overall parity, flips a single indicated bit,
// and flags uncorrectable words. Assumes the layout fixed in hsd_pkg.
module hsd_decoder
    import hsd_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sec_o,
    output logic              ded_o
);
    logic [HAM_W:1]   pos;
    logic [HAM_W:1]   fixed;
    logic [PAR_W-1:0] syn;
    logic             odd;

    assign pos = code_i[HAM_W-1:0];
    assign odd = ^code_i;

    // Syndrome: each bit is the parity over positions with that index bit set.
    always_comb begin
        syn = '0;
        for (int p = 1; p <= HAM_W; p++) begin
            for (int k = 0; k < PAR_W; k++) begin
                if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ pos[p];
            end
        end
    end

    // Classify the word and repair a single in-range position.
    always_comb begin
        fixed = pos;
        sec_o = 1'b0;
        ded_o = 1'b0;
        if (syn != '0) begin
            if (odd && int'(syn) <= HAM_W) begin
                sec_o = 1'b1;
                for (int p = 1; p <= HAM_W; p++) begin
                    if (p == int'(syn)) fixed[p] = ~pos[p];
                end
            end else begin
                ded_o = 1'b1;
            end
        end else if (odd) begin
            sec_o = 1'b1;
        end
    end

    // Gather the data positions of the repaired word, MSB first.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < DATA_W; i++) data_o[DATA_W-1-i] = fixed[data_pos(i)];
    end
endmodule

// File: rtl/hsd_out_stage.sv
// Module: optional output register stage.
// REG=1 registers d_i with a synchronous active-low clear;
// REG=0 is a plain wire and leaves clk and rst_n unused.
module hsd_out_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (REG) begin : g_reg
        // Capture the stage input each cycle, clear while in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_wire
        assign q_o = d_i;
    end
endmodule

// File: rtl/hamming_secded_codec.sv
// Module: top of the 8-bit SEC-DED codec.
// Encoder and decoder are independent combinational paths sharing one
// optional output stage selected by OUT_REG. Inputs are assumed known
// in every cycle, reset cycles included.
module hamming_secded_codec
    import hsd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_sec_o,
    output logic              dec_ded_o
);
    localparam int STAGE_W = CODE_W + DATA_W + 2;

    logic [CODE_W-1:0] enc_code_c;
    logic [DATA_W-1:0] dec_data_c;
    logic              dec_sec_c;
    logic              dec_ded_c;

    hsd_encoder u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    hsd_decoder u_dec (
        .code_i (dec_code_i),
        .data_o (dec_data_c),
        .sec_o  (dec_sec_c),
        .ded_o  (dec_ded_c)
    );

    hsd_out_stage #(.W(STAGE_W), .REG(OUT_REG)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({enc_code_c, dec_data_c, dec_sec_c, dec_ded_c}),
        .q_o   ({enc_code_o, dec_data_o, dec_sec_o, dec_ded_o})
    );

    // The two flags never rise together (R6, R7).
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_sec_o && dec_ded_o));

    // Every encoded word has even weight (R3).
    assert_even_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_code_o) == 1'b0);

    if (OUT_REG) begin : g_chk_reg
        // Reset clears every output at the following edge (R9).
        assert_reset_clear_R9: assert property (@(posedge clk)
            !rst_n |=> (enc_code_o == '0 && dec_data_o == '0 && !dec_sec_o && !dec_ded_o));

        // A received word equal to the encoding decodes cleanly (R8).
        assert_clean_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dec_code_i) == enc_code_o) |->
            (!dec_sec_o && !dec_ded_o && dec_data_o == $past(enc_data_i)));

        // Uncorrectable words pass data positions through (R6).
        assert_ded_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dec_ded_o |-> dec_data_o == raw_data($past(dec_code_i)));

        // A repair changes at most one data bit (R4).
        assert_sec_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dec_sec_o |-> $countones(dec_data_o ^ raw_data($past(dec_code_i))) <= 1);
    end else begin : g_chk_comb
        // A received word equal to the encoding decodes cleanly (R8).
        assert_clean_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_code_i == enc_code_o) |->
            (!dec_sec_o && !dec_ded_o && dec_data_o == enc_data_i));

        // Uncorrectable words pass data positions through (R6).
        assert_ded_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dec_ded_o |-> dec_data_o == raw_data(dec_code_i));

        // A repair changes at most one data bit (R4).
        assert_sec_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dec_sec_o |-> $countones(dec_data_o ^ raw_data(dec_code_i)) <= 1);
    end
endmodule

// File: tb/hamming_secded_codec_tb.sv
// Bench: exhaustive single and double flips over all data values,
// seeded random single flips and directed corner cases.
module hamming_secded_codec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_code_o;
    logic [12:0] dec_code_i = '0;
    logic [7:0]  dec_data_o;
    logic        dec_sec_o;
    logic        dec_ded_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hamming_secded_codec u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_data_i (enc_data_i),
        .enc_code_o (enc_code_o),
        .dec_code_i (dec_code_i),
        .dec_data_o (dec_data_o),
        .dec_sec_o  (dec_sec_o),
        .dec_ded_o  (dec_ded_o)
    );

    // Reference encoding written from R1..R3, vector bit p-1 = position p.
    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic p1, p2, p4, p8, p13;
        p1  = d[7] ^ d[6] ^ d[4] ^ d[3] ^ d[1];
        p2  = d[7] ^ d[5] ^ d[4] ^ d[2] ^ d[1];
        p4  = d[6] ^ d[5] ^ d[4] ^ d[0];
        p8  = d[3] ^ d[2] ^ d[1] ^ d[0];
        p13 = p1 ^ p2 ^ p4 ^ p8 ^ (^d);
        return {p13, d[0], d[1], d[2], d[3], p8, d[4], d[5], d[6], p4, d[7], p2, p1};
    endfunction

    // Data positions of a word, uncorrected (R1 order).
    function automatic logic [7:0] ref_fields(input logic [12:0] c);
        return {c[2], c[4], c[5], c[6], c[8], c[9], c[10], c[11]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one pair of inputs at a falling edge, sample one cycle later.
    task automatic apply(input logic [7:0] d, input logic [12:0] c,
                         input logic [7:0] ed, input bit es, input bit ee, input string req);
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = c;
        @(negedge clk);
        check(enc_code_o == ref_enc(d), "R1/R2 encode", 32'(enc_code_o), 32'(ref_enc(d)));
        check({dec_data_o, dec_sec_o, dec_ded_o} == {ed, es, ee}, req,
              32'({dec_data_o, dec_sec_o, dec_ded_o}), 32'({ed, es, ee}));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [12:0] cw;
        logic [7:0]  d;
        void'($urandom(32'h5EED));
        // R9: reset clears outputs even with live inputs.
        enc_data_i = 8'hFF;
        dec_code_i = ref_enc(8'hA5) ^ 13'h0011;
        repeat (3) @(negedge clk);
        check(enc_code_o == '0 && dec_data_o == '0 && !dec_sec_o && !dec_ded_o, "R9 reset",
              32'({enc_code_o, dec_data_o, dec_sec_o, dec_ded_o}), 32'h0);
        enc_data_i = '0;
        dec_code_i = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: known vector.
        apply(8'h5B, 13'h1DD8, 8'h5B, 1'b0, 1'b0, "R8 clean 0x5B");
        check(enc_code_o == 13'h1DD8, "R3 vector 0x5B", 32'(enc_code_o), 32'h1DD8);

        // R9: one-cycle latency; output holds until the next edge.
        @(negedge clk);
        enc_data_i = 8'h00;
        #1;
        check(enc_code_o == 13'h1DD8, "R9 latency hold", 32'(enc_code_o), 32'h1DD8);
        @(negedge clk);
        check(enc_code_o == 13'h0000, "R9 latency update", 32'(enc_code_o), 32'h0);

        // Exhaustive: clean, all single flips, all double flips.
        for (int v = 0; v < 256; v++) begin
            d  = 8'(v);
            cw = ref_enc(d);
            apply(d, cw, d, 1'b0, 1'b0, "R8 clean");
            for (int a = 0; a < 13; a++) begin
                if (a == 12) apply(d, cw ^ (13'h1 << a), d, 1'b1, 1'b0, "R5 flip pos13");
                else         apply(d, cw ^ (13'h1 << a), d, 1'b1, 1'b0, "R4 single flip");
            end
            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    apply(d, cw ^ (13'h1 << a) ^ (13'h1 << b),
                          ref_fields(cw ^ (13'h1 << a) ^ (13'h1 << b)), 1'b0, 1'b1, "R6 double flip");
                end
            end
        end

        // R7: triple flips whose syndrome lands at 13, 14, 15.
        for (int t = 0; t < 3; t++) begin
            d  = 8'($urandom);
            cw = ref_enc(d) ^ 13'h0088 ^ (13'h1 << t);
            apply(d, cw, ref_fields(cw), 1'b0, 1'b1, "R7 syndrome above 12");
        end

        // Random single flips with the seeded generator.
        for (int r = 0; r < 300; r++) begin
            d  = 8'($urandom);
            cw = ref_enc(d) ^ (13'h1 << ($urandom % 13));
            apply(d, cw, d, 1'b1, 1'b0, "R4 random single flip");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule